// File: doc/BRIEF.md
# Keyed Microphone Supervision Arbiter

This block decides, for each of a set of push-to-talk microphone channels, whether the microphone may go live. Every channel supplies three asynchronous levels: a key-pressed indication, a line-open report and a line-short report from an external supervision circuit. Each level is synchronized and then debounced before any decision uses it. A channel goes live while its key is pressed, its line is not open and no fault is latched.

Pressing the key shorts the supervision pair inside the microphone. A short seen during keying is therefore normal, and the block must not latch it as a fault, however slowly the button travels. A short seen with the key released is judged only after a settle window. If the key arrives inside that window, the short is forgiven. If the window runs out with the key still released, a fault is latched. The window also restarts when the key is released, so a short that lingers after a slow release is still forgiven. A latched fault holds the channel off until the line has reported healthy, with the key released, for one full window. An open line is never excused.

Top module: `mic_key_supervisor`

## Requirements
- R1: While reset is asserted, and right after it, every `talk_en` bit and every `fault_flag` bit is 0.
- R2: With a healthy line and no fault, a key press that stays steady through debounce drives that channel's `talk_en` bit to 1. Releasing the key returns it to 0.
- R3: A short that comes before the key press still lets the channel activate with no fault, provided the key arrives less than SETTLE_CYCLES filtered cycles after the short.
- R4: A short that arrives together with the key press, or while the key is held, never sets the fault flag, however long it lasts.
- R5: A short held with the key released for SETTLE_CYCLES consecutive filtered cycles latches `fault_flag`. While the flag is set, `talk_en` stays 0 even if the key is pressed.
- R6: A debounced open latches `fault_flag` on the next cycle and forces `talk_en` to 0, whether or not the key is held.
- R7: A latched fault clears only after SETTLE_CYCLES consecutive cycles with no open, no short and the key released. A healthy line while the key is held does not clear it.
- R8: After the key is released, a short that persists for less than one settle window does not set the fault flag.
- R9: A pulse on any input that lasts fewer than DEBOUNCE_CYCLES clocks has no effect on `talk_en` or `fault_flag`.
- R10: Channels are independent. A fault on one channel does not change the flags or enables of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ptt_async | input | CHANNELS | Key-pressed level per channel, asynchronous |
| line_open_async | input | CHANNELS | Supervision reports an open line, asynchronous |
| line_short_async | input | CHANNELS | Supervision reports a shorted line, asynchronous |
| talk_en | output | CHANNELS | Microphone activation enable per channel |
| fault_flag | output | CHANNELS | Latched line fault per channel |

## Verification
The critical coincidence is the settle window running out in the same cycle that the filtered key indication arrives. At that edge one of two outcomes wins: the short is forgiven, or it is latched. The bench forces this case by raising a short on two channels at once. It then presses the key SETTLE_CYCLES-1 clocks later on one channel and SETTLE_CYCLES clocks later on the other. Both inputs pass through identical filters, so the offset reaches the decision logic unchanged. The first channel must end up live with no fault, and the second must end up faulted and held off.

// File: rtl/mksup_pkg.sv
`timescale 1ns/1ps
package mksup_pkg;

   // per-channel supervision state
   typedef enum logic {
      CH_ARMED = 1'b0,
      CH_FAULT = 1'b1
   } ch_state_e;

   localparam int unsigned DEF_CHANNELS      = 8;
   localparam int unsigned DEF_SYNC_STAGES   = 2;
   localparam int unsigned DEF_DEBOUNCE      = 16;
   localparam int unsigned DEF_SETTLE        = 256;

endpackage

// File: rtl/mksup_level_filter.sv
`timescale 1ns/1ps
module mksup_level_filter #(
   parameter int unsigned SYNC_STAGES     = 2,
   parameter int unsigned DEBOUNCE_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din_async,
   output logic dout
);

   localparam int unsigned DW = (DEBOUNCE_CYCLES > 1) ? $clog2(DEBOUNCE_CYCLES) : 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("mksup_level_filter: SYNC_STAGES must be at least 2");
      end
      if (DEBOUNCE_CYCLES < 1) begin : g_bad_deb
         $error("mksup_level_filter: DEBOUNCE_CYCLES must be at least 1");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] chain_q;
   logic                   synced;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[SYNC_STAGES-2:0], din_async};
   end

   assign synced = chain_q[SYNC_STAGES-1];

   generate
      if (DEBOUNCE_CYCLES == 1) begin : g_no_debounce
         assign dout = synced;
      end else begin : g_debounce
         logic [DW-1:0] run_q;
         logic          level_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q   <= '0;
               level_q <= 1'b0;
            end else if (synced == level_q) begin
               run_q <= '0;
            end else if (run_q == DW'(DEBOUNCE_CYCLES - 1)) begin
               run_q   <= '0;
               level_q <= synced;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end

         assign dout = level_q;
      end
   endgenerate

endmodule

// File: rtl/mksup_channel.sv
`timescale 1ns/1ps
module mksup_channel
   import mksup_pkg::*;
#(
   parameter int unsigned SETTLE_CYCLES = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ptt_i,
   input  logic open_i,
   input  logic short_i,
   output logic talk_o,
   output logic fault_o
);

   localparam int unsigned CW = $clog2(SETTLE_CYCLES + 1);

   generate
      if (SETTLE_CYCLES < 2) begin : g_bad_settle
         $error("mksup_channel: SETTLE_CYCLES must be at least 2");
      end
   endgenerate

   ch_state_e     state_q, state_d;
   logic [CW-1:0] win_q, win_d;
   logic          win_run;
   logic          win_done;

   // armed: time a short seen with the key released
   // faulted: time a healthy line seen with the key released
   always_comb begin
      if (state_q == CH_ARMED) win_run = short_i & ~ptt_i & ~open_i;
      else                     win_run = ~short_i & ~ptt_i & ~open_i;
      win_done = win_run && (win_q == CW'(SETTLE_CYCLES - 1));
   end

   always_comb begin
      state_d = state_q;
      win_d   = '0;
      if (open_i) begin
         state_d = CH_FAULT;
      end else if (win_done) begin
         state_d = (state_q == CH_ARMED) ? CH_FAULT : CH_ARMED;
      end else if (win_run) begin
         win_d = win_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CH_ARMED;
         win_q   <= '0;
      end else begin
         state_q <= state_d;
         win_q   <= win_d;
      end
   end

   assign talk_o  = ptt_i & ~open_i & (state_q == CH_ARMED);
   assign fault_o = (state_q == CH_FAULT);

endmodule

// File: rtl/mic_key_supervisor.sv
`timescale 1ns/1ps
module mic_key_supervisor
   import mksup_pkg::*;
#(
   parameter int unsigned CHANNELS        = DEF_CHANNELS,
   parameter int unsigned SYNC_STAGES     = DEF_SYNC_STAGES,
   parameter int unsigned DEBOUNCE_CYCLES = DEF_DEBOUNCE,
   parameter int unsigned SETTLE_CYCLES   = DEF_SETTLE
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [CHANNELS-1:0] ptt_async,
   input  logic [CHANNELS-1:0] line_open_async,
   input  logic [CHANNELS-1:0] line_short_async,
   output logic [CHANNELS-1:0] talk_en,
   output logic [CHANNELS-1:0] fault_flag
);

   generate
      if (CHANNELS < 1) begin : g_bad_channels
         $error("mic_key_supervisor: CHANNELS must be at least 1");
      end
   endgenerate

   logic [CHANNELS-1:0] ptt_clean;
   logic [CHANNELS-1:0] open_clean;
   logic [CHANNELS-1:0] short_clean;

   for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
      mksup_level_filter #(
         .SYNC_STAGES    (SYNC_STAGES),
         .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)
      ) u_ptt_filt (
         .clk      (clk),
         .rst_n    (rst_n),
         .din_async(ptt_async[c]),
         .dout     (ptt_clean[c])
      );

      mksup_level_filter #(
         .SYNC_STAGES    (SYNC_STAGES),
         .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)
      ) u_open_filt (
         .clk      (clk),
         .rst_n    (rst_n),
         .din_async(line_open_async[c]),
         .dout     (open_clean[c])
      );

      mksup_level_filter #(
         .SYNC_STAGES    (SYNC_STAGES),
         .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)
      ) u_short_filt (
         .clk      (clk),
         .rst_n    (rst_n),
         .din_async(line_short_async[c]),
         .dout     (short_clean[c])
      );

      mksup_channel #(
         .SETTLE_CYCLES(SETTLE_CYCLES)
      ) u_ctl (
         .clk    (clk),
         .rst_n  (rst_n),
         .ptt_i  (ptt_clean[c]),
         .open_i (open_clean[c]),
         .short_i(short_clean[c]),
         .talk_o (talk_en[c]),
         .fault_o(fault_flag[c])
      );
   end

endmodule

// File: rtl/mksup_checker.sv
`timescale 1ns/1ps
module mksup_checker #(
   parameter int unsigned CHANNELS = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic [CHANNELS-1:0] ptt_clean,
   input logic [CHANNELS-1:0] open_clean,
   input logic [CHANNELS-1:0] short_clean,
   input logic [CHANNELS-1:0] talk_en,
   input logic [CHANNELS-1:0] fault_flag
);

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (talk_en == '0 && fault_flag == '0));

   for (genvar c = 0; c < CHANNELS; c++) begin : g_chk
      // R5
      talk_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(talk_en[c] && fault_flag[c]));

      // R6
      open_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
         open_clean[c] |=> fault_flag[c]);

      // R4
      keyed_short_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(fault_flag[c]) |-> $past(open_clean[c] || !ptt_clean[c]));

      // R7
      clear_healthy_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(fault_flag[c]) |->
            $past(!ptt_clean[c] && !open_clean[c] && !short_clean[c]));
   end

endmodule

bind mic_key_supervisor mksup_checker #(.CHANNELS(CHANNELS)) u_mksup_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ptt_clean  (ptt_clean),
   .open_clean (open_clean),
   .short_clean(short_clean),
   .talk_en    (talk_en),
   .fault_flag (fault_flag)
);

// File: tb/mic_key_supervisor_test.sv
`timescale 1ns/1ps
module mic_key_supervisor_test;

   localparam int CH  = 8;
   localparam int DEB = 4;
   localparam int SET = 40;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [CH-1:0] ptt = '0;
   logic [CH-1:0] opn = '0;
   logic [CH-1:0] sht = '0;
   logic [CH-1:0] talk;
   logic [CH-1:0] flt;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   mic_key_supervisor #(
      .CHANNELS       (CH),
      .SYNC_STAGES    (2),
      .DEBOUNCE_CYCLES(DEB),
      .SETTLE_CYCLES  (SET)
   ) uut (
      .clk             (clk),
      .rst_n           (rst_n),
      .ptt_async       (ptt),
      .line_open_async (opn),
      .line_short_async(sht),
      .talk_en         (talk),
      .fault_flag      (flt)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      idle(3);
      chk(talk == '0, "R1 talk in reset", int'(talk), 0);
      chk(flt == '0, "R1 fault in reset", int'(flt), 0);
      rst_n = 1'b1;
      idle(2);
      chk(talk == '0 && flt == '0, "R1 after reset", int'({talk, flt}), 0);
   endtask

   task automatic t_fast_key;
      ptt[0] = 1'b1; sht[0] = 1'b1;
      idle(20);
      chk(talk[0] == 1'b1, "R2 fast key activates", int'(talk[0]), 1);
      chk(flt[0] == 1'b0, "R4 fast key no fault", int'(flt[0]), 0);
      idle(SET + 20);
      chk(flt[0] == 1'b0 && talk[0] == 1'b1, "R4 long keyed short", int'({talk[0], flt[0]}), 2);
      ptt[0] = 1'b0; sht[0] = 1'b0;
      idle(20);
      chk(talk[0] == 1'b0, "R2 release drops enable", int'(talk[0]), 0);
   endtask

   task automatic t_slow_key;
      sht[1] = 1'b1;
      idle(SET / 2);
      ptt[1] = 1'b1;
      idle(20);
      chk(talk[1] == 1'b1, "R3 slow key activates", int'(talk[1]), 1);
      idle(2 * SET);
      chk(flt[1] == 1'b0, "R3 slow key no fault", int'(flt[1]), 0);
      ptt[1] = 1'b0; sht[1] = 1'b0;
      idle(20);
   endtask

   task automatic t_slow_release;
      ptt[2] = 1'b1; sht[2] = 1'b1;
      idle(20);
      ptt[2] = 1'b0;
      idle(SET / 2);
      chk(flt[2] == 1'b0, "R8 lingering short masked", int'(flt[2]), 0);
      sht[2] = 1'b0;
      idle(2 * SET);
      chk(flt[2] == 1'b0, "R8 no fault after release", int'(flt[2]), 0);
      chk(talk[2] == 1'b0, "R2 enable off after release", int'(talk[2]), 0);
   endtask

   task automatic t_real_short;
      sht[3] = 1'b1;
      idle(SET / 2);
      chk(flt[3] == 1'b0, "R5 short inside window", int'(flt[3]), 0);
      idle(SET);
      chk(flt[3] == 1'b1, "R5 short latched", int'(flt[3]), 1);
      chk(flt == 8'h08, "R10 only channel 3 faulted", int'(flt), 8);
      ptt[3] = 1'b1;
      idle(20);
      chk(talk[3] == 1'b0, "R5 fault holds enable off", int'(talk[3]), 0);
      sht[3] = 1'b0;
      idle(2 * SET);
      chk(flt[3] == 1'b1, "R7 no clear while keyed", int'(flt[3]), 1);
      ptt[3] = 1'b0;
      idle(SET / 2);
      chk(flt[3] == 1'b1, "R7 clear waits full window", int'(flt[3]), 1);
      idle(SET);
      chk(flt[3] == 1'b0, "R7 clears after healthy window", int'(flt[3]), 0);
      ptt[3] = 1'b1;
      idle(20);
      chk(talk[3] == 1'b1, "R7 activates after clear", int'(talk[3]), 1);
      ptt[3] = 1'b0;
      idle(20);
   endtask

   task automatic t_open;
      ptt[4] = 1'b1;
      idle(20);
      chk(talk[4] == 1'b1, "R2 healthy key", int'(talk[4]), 1);
      opn[4] = 1'b1;
      idle(20);
      chk(talk[4] == 1'b0, "R6 open forces enable off", int'(talk[4]), 0);
      chk(flt[4] == 1'b1, "R6 open latches fault", int'(flt[4]), 1);
      opn[4] = 1'b0;
      idle(2 * SET);
      chk(flt[4] == 1'b1, "R7 keyed healthy line keeps fault", int'(flt[4]), 1);
      ptt[4] = 1'b0;
      idle(SET + 30);
      chk(flt[4] == 1'b0, "R7 open fault clears", int'(flt[4]), 0);
   endtask

   task automatic t_glitch;
      bit seen = 1'b0;
      ptt[5] = 1'b1;
      idle(2);
      ptt[5] = 1'b0;
      for (int i = 0; i < 20; i++) begin
         idle(1);
         if (talk[5]) seen = 1'b1;
      end
      chk(seen == 1'b0, "R9 short key pulse ignored", int'(seen), 0);
      opn[5] = 1'b1;
      idle(2);
      opn[5] = 1'b0;
      idle(20);
      chk(flt[5] == 1'b0, "R9 short open pulse ignored", int'(flt[5]), 0);
   endtask

   task automatic t_window_edge;
      sht[6] = 1'b1; sht[7] = 1'b1;
      idle(SET - 1);
      ptt[6] = 1'b1;
      idle(1);
      ptt[7] = 1'b1;
      idle(20);
      chk(flt[6] == 1'b0, "R3 key on last window cycle", int'(flt[6]), 0);
      chk(talk[6] == 1'b1, "R3 key on last window cycle talks", int'(talk[6]), 1);
      chk(flt[7] == 1'b1, "R5 key one cycle late", int'(flt[7]), 1);
      chk(talk[7] == 1'b0, "R5 late key held off", int'(talk[7]), 0);
      chk(flt == 8'h80, "R10 fault vector", int'(flt), 128);
   endtask

   initial begin
      t_reset();
      t_fast_key();
      t_slow_key();
      t_slow_release();
      t_real_short();
      t_open();
      t_glitch();
      t_window_edge();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual=running expected=done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule